// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block controls 32 general-purpose pins through a small synchronous register bus. The pins are grouped into four identical banks of eight. Each bank has its own 64-byte register window. In that window software sets the pin direction, drives output values, reads the synchronised pin levels and manages one interrupt source per pin. Each pin interrupt is either edge or level triggered. The bank keeps a raw pending view, a view masked by the per-pin mask, and separate write strobes that set mask bits and clear them. The masked pending bits of all banks are ORed onto a single interrupt line.

Each pin input passes through a synchroniser before it reaches the input view or the interrupt logic. Each output pin drives the value held in its output data register whenever its direction bit is 0. The pad, pull resistors and pin multiplexing live outside this block, as does any bridge to a system bus.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Bank k answers at byte addresses k*0x40 to k*0x40+0x3F. Pin n is bit n%8 of bank n/8. Register offsets within a bank: 0x00 masked pending (read-only), 0x04 raw pending, 0x08 mask set and mask readback, 0x0C mask clear (write-only), 0x10 direction, 0x14 output data, 0x18 input view, 0x20 trigger select. Any other offset reads 0, and bus_rdata bits 31:8 always read 0.
- R2: After reset every mask bit is 1, every direction bit is 1, every output bit is 0, every trigger select bit is 0 and every pending bit is 0. pin_oe and irq are 0.
- R3: A direction bit of 1 makes the pin an input, with pin_oe low. A direction bit of 0 raises pin_oe, and pin_out then carries the matching bit of the output data register. Both registers read back what was written.
- R4: Offset 0x18 returns the pin levels delayed by two clock edges through a synchroniser.
- R5: When a pin's trigger select bit is 0, a rising edge of its synchronised level sets its pending bit. A falling edge or a steady level does not set it.
- R6: When a pin's trigger select bit is 1, its pending bit is set on every cycle that its synchronised level is high. A clear has no lasting effect while the level stays high. Once the level has dropped the bit stays set until it is cleared.
- R7: Writing offset 0x04 clears each pending bit whose write data bit is 1. Bits written as 0 keep their state.
- R8: Writing 1s to offset 0x08 sets those mask bits. Writing 1s to offset 0x0C clears those mask bits. Offset 0x08 reads the mask, and offset 0x0C reads 0.
- R9: Offset 0x00 reads the pending bits ANDed with the inverted mask. A write to offset 0x00 changes no state.
- R10: irq is high exactly when some bank has a pending bit whose mask bit is 0.
- R11: If a pending clear and a new set condition for the same pin fall in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address; bits 7:6 select the bank, bits 5:0 the register |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output values for the pins |
| pin_oe | output | 32 | Output enables, 1 = drive |
| irq | output | 1 | OR of all masked pending bits |

## Verification
Software clearing a pending bit and hardware setting it can land on the same clock edge. The bench provokes this for an edge-mode pin. A clear was already pending on that pin. The bench raises the pin and counts the two synchroniser edges, so that the status write commits on the very edge where the rising edge is detected. The raw status read afterwards must still show the bit, and a second clear with the pin held high must then remove it. For a level-mode pin the collision is steady: a clear issued while the pin stays high must read back as still set.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   // Bytes per bank window and the offset width they imply
   localparam int BANK_BYTES = 64;
   localparam int OFF_W      = $clog2(BANK_BYTES);

   // Register offsets inside one bank window
   localparam logic [OFF_W-1:0] OFF_PEND_MSK = 6'h00;
   localparam logic [OFF_W-1:0] OFF_PEND_RAW = 6'h04;
   localparam logic [OFF_W-1:0] OFF_MASK_SET = 6'h08;
   localparam logic [OFF_W-1:0] OFF_MASK_CLR = 6'h0C;
   localparam logic [OFF_W-1:0] OFF_DIR      = 6'h10;
   localparam logic [OFF_W-1:0] OFF_DOUT     = 6'h14;
   localparam logic [OFF_W-1:0] OFF_DIN      = 6'h18;
   localparam logic [OFF_W-1:0] OFF_TRIG     = 6'h20;

   typedef enum logic [2:0] {
      ACC_NONE, ACC_PEND_CLR, ACC_MASK_SET, ACC_MASK_CLR,
      ACC_DIR, ACC_DOUT, ACC_TRIG
   } bank_wr_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("gpio_pin_sync: STAGES must be 2..4");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_pin_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_src.sv
module gpio_trig_src #(
   parameter int PINS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] level,
   input  logic [PINS-1:0] lvl_mode,
   output logic [PINS-1:0] set_req
);
   logic [PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      always_comb begin
         if (lvl_mode[p]) set_req[p] = level[p];
         else             set_req[p] = level[p] & ~prev_q[p];
      end
   end

   // R5
   edge_only_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_req & ~lvl_mode) != '0) |-> ((level & ~$past(level) & ~lvl_mode) == (set_req & ~lvl_mode)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int PINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [OFF_W-1:0] reg_off,
   input  logic [PINS-1:0]  wdata,
   input  logic [PINS-1:0]  pin_lvl,
   output logic [PINS-1:0]  rd_data,
   output logic [PINS-1:0]  drv_val,
   output logic [PINS-1:0]  drv_en,
   output logic [PINS-1:0]  pend_vis
);
   logic [PINS-1:0] dir_q, dout_q, mask_q, trig_q, pend_q;
   logic [PINS-1:0] set_req, clr_vec;
   bank_wr_e        acc;

   gpio_trig_src #(.PINS(PINS)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (pin_lvl),
      .lvl_mode (trig_q),
      .set_req  (set_req)
   );

   always_comb begin
      acc = ACC_NONE;
      if (wr_en) begin
         unique case (reg_off)
            OFF_PEND_RAW: acc = ACC_PEND_CLR;
            OFF_MASK_SET: acc = ACC_MASK_SET;
            OFF_MASK_CLR: acc = ACC_MASK_CLR;
            OFF_DIR:      acc = ACC_DIR;
            OFF_DOUT:     acc = ACC_DOUT;
            OFF_TRIG:     acc = ACC_TRIG;
            default:      acc = ACC_NONE;
         endcase
      end
   end

   assign clr_vec = (acc == ACC_PEND_CLR) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '1;
         dout_q <= '0;
         mask_q <= '1;
         trig_q <= '0;
         pend_q <= '0;
      end else begin
         pend_q <= (pend_q & ~clr_vec) | set_req;
         case (acc)
            ACC_MASK_SET: mask_q <= mask_q | wdata;
            ACC_MASK_CLR: mask_q <= mask_q & ~wdata;
            ACC_DIR:      dir_q  <= wdata;
            ACC_DOUT:     dout_q <= wdata;
            ACC_TRIG:     trig_q <= wdata;
            default:      ;
         endcase
      end
   end

   assign pend_vis = pend_q & ~mask_q;
   assign drv_val  = dout_q;
   assign drv_en   = ~dir_q;

   always_comb begin
      unique case (reg_off)
         OFF_PEND_MSK: rd_data = pend_vis;
         OFF_PEND_RAW: rd_data = pend_q;
         OFF_MASK_SET: rd_data = mask_q;
         OFF_DIR:      rd_data = dir_q;
         OFF_DOUT:     rd_data = dout_q;
         OFF_DIN:      rd_data = pin_lvl;
         OFF_TRIG:     rd_data = trig_q;
         default:      rd_data = '0;
      endcase
   end

   // R5 R11
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req != '0) |=> ((pend_q & $past(set_req)) == $past(set_req)));

   // R6
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((trig_q & pin_lvl) != '0) |=> ((pend_q & $past(trig_q & pin_lvl)) == $past(trig_q & pin_lvl)));

   // R7
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_off == OFF_PEND_RAW) |=> ((pend_q & $past(wdata & ~set_req)) == '0));

   // R8
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_off == OFF_MASK_SET) |=> ((mask_q & $past(wdata)) == $past(wdata)));

   // R8
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_off == OFF_MASK_CLR) |=> ((mask_q & $past(wdata)) == '0));

   // R3
   dir_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_off == OFF_DIR) |=> (drv_en == ~$past(wdata)));

   // R9
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_off == OFF_PEND_MSK) |=> ($stable(mask_q) && $stable(dir_q) && $stable(dout_q) && $stable(trig_q)));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_BANKS   = 4,
   parameter int BANK_PINS   = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   localparam int NPINS      = NUM_BANKS * BANK_PINS,
   localparam int SEL_W      = $clog2(NUM_BANKS),
   localparam int ADDR_W     = OFF_W + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("gpio_bank_ctrl: NUM_BANKS must be a power of two >= 2");
   end
   if (BANK_PINS < 1 || BANK_PINS > DATA_W) begin : g_bad_pins
      $error("gpio_bank_ctrl: BANK_PINS must fit in DATA_W");
   end

   logic [NPINS-1:0]     pin_sync;
   logic [NPINS-1:0]     pend_all;
   logic [SEL_W-1:0]     bank_sel;
   logic [OFF_W-1:0]     reg_off;
   logic [BANK_PINS-1:0] rd_arr [NUM_BANKS];

   assign bank_sel = bus_addr[ADDR_W-1 -: SEL_W];
   assign reg_off  = bus_addr[OFF_W-1:0];

   gpio_pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (pin_sync)
   );

   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
      gpio_bank #(.PINS(BANK_PINS)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (bus_wr && (bank_sel == SEL_W'(k))),
         .reg_off  (reg_off),
         .wdata    (bus_wdata[BANK_PINS-1:0]),
         .pin_lvl  (pin_sync[k*BANK_PINS +: BANK_PINS]),
         .rd_data  (rd_arr[k]),
         .drv_val  (pin_out[k*BANK_PINS +: BANK_PINS]),
         .drv_en   (pin_oe[k*BANK_PINS +: BANK_PINS]),
         .pend_vis (pend_all[k*BANK_PINS +: BANK_PINS])
      );
   end

   assign bus_rdata = DATA_W'(rd_arr[bank_sel]);
   assign irq       = |pend_all;

   // R10
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq)) |-> ($past(pend_all) == '0 && pend_all != '0));
endmodule

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 49;
   localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_PIN = 3'd2,
                          OP_IRQ = 3'd3, OP_OE = 3'd4, OP_OUT = 3'd5;

   typedef struct packed {
      logic [3:0]  req;
      logic [2:0]  op;
      logic [7:0]  a;
      logic [31:0] d;
      logic [31:0] e;
   } vec_t;

   localparam vec_t VEC [NV] = '{
      {4'd3,  OP_WR,  8'h50, 32'h0F, 32'h0},        // R3
      {4'd3,  OP_RD,  8'h50, 32'h0,  32'h0F},       // R3
      {4'd3,  OP_WR,  8'h54, 32'hA0, 32'h0},        // R3
      {4'd3,  OP_RD,  8'h54, 32'h0,  32'hA0},       // R3
      {4'd3,  OP_OE,  8'h00, 32'h0,  32'h0000F000}, // R3
      {4'd3,  OP_OUT, 8'h00, 32'h0,  32'h0000A000}, // R3
      {4'd1,  OP_RD,  8'h94, 32'h0,  32'h0},        // R1
      {4'd5,  OP_PIN, 8'h00, 32'h05, 32'h0},        // R5
      {4'd4,  OP_RD,  8'h18, 32'h0,  32'h05},       // R4
      {4'd5,  OP_RD,  8'h04, 32'h0,  32'h05},       // R5
      {4'd9,  OP_RD,  8'h00, 32'h0,  32'h0},        // R9
      {4'd10, OP_IRQ, 8'h00, 32'h0,  32'h0},        // R10
      {4'd8,  OP_WR,  8'h0C, 32'h01, 32'h0},        // R8
      {4'd8,  OP_RD,  8'h08, 32'h0,  32'hFE},       // R8
      {4'd8,  OP_RD,  8'h0C, 32'h0,  32'h0},        // R8
      {4'd9,  OP_RD,  8'h00, 32'h0,  32'h01},       // R9
      {4'd10, OP_IRQ, 8'h00, 32'h0,  32'h1},        // R10
      {4'd9,  OP_WR,  8'h00, 32'hFF, 32'h0},        // R9
      {4'd9,  OP_RD,  8'h04, 32'h0,  32'h05},       // R9
      {4'd7,  OP_WR,  8'h04, 32'h04, 32'h0},        // R7
      {4'd7,  OP_RD,  8'h04, 32'h0,  32'h01},       // R7
      {4'd5,  OP_PIN, 8'h00, 32'h0,  32'h0},        // R5
      {4'd5,  OP_RD,  8'h04, 32'h0,  32'h01},       // R5
      {4'd7,  OP_WR,  8'h04, 32'h01, 32'h0},        // R7
      {4'd7,  OP_RD,  8'h04, 32'h0,  32'h0},        // R7
      {4'd10, OP_IRQ, 8'h00, 32'h0,  32'h0},        // R10
      {4'd8,  OP_WR,  8'h08, 32'h01, 32'h0},        // R8
      {4'd8,  OP_RD,  8'h08, 32'h0,  32'hFF},       // R8
      {4'd1,  OP_PIN, 8'h00, 32'h00010000, 32'h0},  // R1
      {4'd1,  OP_RD,  8'h98, 32'h0,  32'h01},       // R1
      {4'd1,  OP_RD,  8'h84, 32'h0,  32'h01},       // R1
      {4'd7,  OP_WR,  8'h84, 32'h01, 32'h0},        // R7
      {4'd5,  OP_RD,  8'h84, 32'h0,  32'h0},        // R5
      {4'd6,  OP_WR,  8'hE0, 32'h02, 32'h0},        // R6
      {4'd6,  OP_RD,  8'hE0, 32'h0,  32'h02},       // R6
      {4'd6,  OP_PIN, 8'h00, 32'h02000000, 32'h0},  // R6
      {4'd6,  OP_RD,  8'hC4, 32'h0,  32'h02},       // R6
      {4'd6,  OP_WR,  8'hC4, 32'h02, 32'h0},        // R6
      {4'd6,  OP_RD,  8'hC4, 32'h0,  32'h02},       // R6
      {4'd8,  OP_WR,  8'hCC, 32'h02, 32'h0},        // R8
      {4'd10, OP_IRQ, 8'h00, 32'h0,  32'h1},        // R10
      {4'd9,  OP_RD,  8'hC0, 32'h0,  32'h02},       // R9
      {4'd6,  OP_PIN, 8'h00, 32'h0,  32'h0},        // R6
      {4'd6,  OP_RD,  8'hC4, 32'h0,  32'h02},       // R6
      {4'd6,  OP_WR,  8'hC4, 32'h02, 32'h0},        // R6
      {4'd6,  OP_RD,  8'hC4, 32'h0,  32'h0},        // R6
      {4'd10, OP_IRQ, 8'h00, 32'h0,  32'h0},        // R10
      {4'd1,  OP_RD,  8'h1C, 32'h0,  32'h0},        // R1
      {4'd1,  OP_RD,  8'hFC, 32'h0,  32'h0}         // R1
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic        irq;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   gpio_bank_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq       (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0;
      #1;
      check(tag, bus_rdata, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state
      for (int k = 0; k < 4; k++) begin
         rd("R2 mask", 8'(k*64 + 8), 32'hFF);
         rd("R2 dir", 8'(k*64 + 16), 32'hFF);
         rd("R2 dout", 8'(k*64 + 20), 32'h0);
         rd("R2 pend", 8'(k*64 + 4), 32'h0);
      end
      check("R2 pin_oe", pin_oe, 32'h0);
      check("R2 irq", {31'b0, irq}, 32'h0);

      // vector walk
      for (int i = 0; i < NV; i++) begin
         case (VEC[i].op)
            OP_WR:  wr(VEC[i].a, VEC[i].d);
            OP_RD:  rd($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].a, VEC[i].e);
            OP_PIN: begin
               @(negedge clk);
               pin_in = VEC[i].d;
               repeat (4) @(negedge clk);
            end
            OP_IRQ: begin
               @(negedge clk);
               check($sformatf("R%0d vec%0d irq", VEC[i].req, i), {31'b0, irq}, VEC[i].e);
            end
            OP_OE: begin
               @(negedge clk);
               check($sformatf("R%0d vec%0d oe", VEC[i].req, i), pin_oe, VEC[i].e);
            end
            default: begin
               @(negedge clk);
               check($sformatf("R%0d vec%0d out", VEC[i].req, i), pin_out, VEC[i].e);
            end
         endcase
      end

      // R11: clear and fresh rising edge on the same edge, pin 3 of bank 0
      @(negedge clk); pin_in = 32'h8;
      repeat (4) @(negedge clk);
      pin_in = 32'h0;
      repeat (4) @(negedge clk);
      rd("R11 pre", 8'h04, 32'h08);
      pin_in = 32'h8;          // driven at a falling edge
      @(negedge clk);          // first sync stage loaded
      @(negedge clk);          // second stage loaded, rise now visible
      bus_addr = 8'h04; bus_wdata = 32'h08; bus_wr = 1'b1;
      @(negedge clk);          // clear and set commit on the same edge
      bus_wr = 1'b0;
      rd("R11 set wins", 8'h04, 32'h08);
      wr(8'h04, 32'h08);       // pin held high, edge mode: clear sticks
      rd("R11 later clear", 8'h04, 32'h00);
      finish_run();
   end
endmodule